// File: doc/BRIEF.md
# Instruction Fetch and Address Modification

This block runs the datapath half of an instruction fetch for a machine with 24-bit words. A fetch request starts it. It picks the memory address from either its own program counter or an alternate address that the branch, execute, interrupt or protect logic supplies. It holds that address on a memory read port until the memory signals data ready. It then captures the returned word in a buffer register.

One cycle later the block loads the instruction register. The upper ten bits go in as the opcode. The low fourteen bits go in as the operand address, first passed through an adder that applies relative addressing when the word asks for it. When the word carries a nonzero index tag, the block spends one more cycle adding the tagged index cell to the operand. It then raises a one-cycle done strobe. The execution logic can then address memory straight from the operand field.

The index cells live inside the block. They are written through a simple write port. Tag value zero means no indexing, so there is no cell zero.

Top module: `ifetch_addr_mod`

## Requirements
- R1: While reset is held, and from an asynchronous reset asserted mid-fetch, `mem_req`, `busy` and `fetch_done` are 0, `ir_opcode` and `ir_operand` are 0, and `pc` equals the `RESET_PC` parameter; every index cell reads as zero afterwards.
- R2: A fetch started with `alt_sel` = 0 drives `mem_addr` with the current `pc`; once the word is captured, `pc` advances by one modulo 2^ADDR_W.
- R3: A fetch started with `alt_sel` = 1 drives `mem_addr` with `alt_addr` sampled with `fetch_start`, and leaves `pc` unchanged.
- R4: `mem_req` and `mem_addr` stay constant until a cycle with `mem_rdy` high. `fetch_start` is ignored while `busy` is 1. After the done strobe the block is idle with `mem_req` low.
- R5: `ir_opcode` receives bits 23 down to 14 of the captured word.
- R6: With bit 14 of the word 0 and tag zero, `ir_operand` receives bits 13 down to 0 unchanged.
- R7: With bit 14 of the word 1, the operand becomes bits 13 down to 0 plus the address the word was fetched from, modulo 2^ADDR_W.
- R8: Bits 17 down to 15 form the index tag. A nonzero tag N adds index cell N to the (possibly relative) operand, modulo 2^ADDR_W. The add takes one extra cycle, so the done strobe follows data ready by three cycles.
- R9: A zero index tag causes no index cycle; the done strobe follows the data-ready cycle by two cycles.
- R10: A write with `idx_we` = 1 stores `idx_wdata` into cell `idx_wsel` (1 to 7) at the clock edge. A later write to the same cell replaces it, and the next indexed fetch uses the newest value.
- R11: `fetch_done` is high for exactly one cycle per fetch, and `ir_opcode` and `ir_operand` hold their values after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| fetch_start | input | 1 | Begin a fetch (taken only when idle) |
| alt_sel | input | 1 | Use the alternate address for this fetch |
| alt_addr | input | ADDR_W | Alternate fetch address |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | ADDR_W | Memory read address |
| mem_rdy | input | 1 | Data ready from memory |
| mem_rdata | input | WORD_W | Word returned by memory |
| idx_we | input | 1 | Index cell write enable |
| idx_wsel | input | TAG_W | Index cell number to write |
| idx_wdata | input | ADDR_W | Index cell write data |
| pc | output | ADDR_W | Program counter |
| ir_opcode | output | WORD_W-ADDR_W | Instruction register opcode field |
| ir_operand | output | ADDR_W | Instruction register operand address |
| busy | output | 1 | A fetch is in progress |
| fetch_done | output | 1 | One-cycle strobe: instruction register final |

## Verification
The bench keeps the default 24-bit word, 14-bit address and 3-bit tag. It sets `RESET_PC` to two below the top of the address space, so the second sequential fetch already carries the counter across its wrap point. Index cell 7 is loaded with the all-ones value, and a relative word is fetched from the top address. Together these drive both adders through their modulo-2^14 wrap within a short vector table. Memory wait states of zero to three cycles, with a stray start pulse during the wait, exercise the hold and ignore behaviour.

// File: rtl/ifam_pkg.sv
package ifam_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_FETCH  = 2'd1,
    ST_DECODE = 2'd2,
    ST_INDEX  = 2'd3
  } fsm_e;
endpackage

// File: rtl/ifam_rst_sync.sv
module ifam_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ni
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_ni = sync_q[1];
endmodule

// File: rtl/ifam_seq.sv
module ifam_seq
  import ifam_pkg::*;
(
  input  logic clk,
  input  logic rst_ni,
  input  logic start,
  input  logic mem_rdy,
  input  logic tag_nz,
  output logic launch,
  output logic req,
  output logic ld_ir,
  output logic idx_step,
  output logic busy,
  output logic done
);
  fsm_e st_q, st_d;
  logic done_q, done_d;

  always_comb begin
    st_d   = st_q;
    done_d = 1'b0;
    case (st_q)
      ST_IDLE:   if (start) st_d = ST_FETCH;
      ST_FETCH:  if (mem_rdy) st_d = ST_DECODE;
      ST_DECODE: begin
        if (tag_nz) begin
          st_d = ST_INDEX;
        end else begin
          st_d   = ST_IDLE;
          done_d = 1'b1;
        end
      end
      ST_INDEX: begin
        st_d   = ST_IDLE;
        done_d = 1'b1;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= done_d;
    end
  end

  assign launch   = (st_q == ST_IDLE) && start;
  assign req      = (st_q == ST_FETCH);
  assign ld_ir    = (st_q == ST_DECODE);
  assign idx_step = (st_q == ST_INDEX);
  assign busy     = (st_q != ST_IDLE);
  assign done     = done_q;

  // R4: request held until memory answers
  p_req_hold_r4: assert property (@(posedge clk) disable iff (!rst_ni)
    (req && !mem_rdy) |=> req);
  // R11: strobe lasts one cycle
  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_ni)
    done |=> !done);
  // R9: zero tag goes straight to done with no index cycle
  p_no_idx_r9: assert property (@(posedge clk) disable iff (!rst_ni)
    (ld_ir && !tag_nz) |=> (done && !idx_step));
  // R8: an index cycle always follows a decode
  p_idx_after_decode_r8: assert property (@(posedge clk) disable iff (!rst_ni)
    idx_step |-> $past(ld_ir));
endmodule

// File: rtl/ifam_addr.sv
module ifam_addr #(
  parameter int unsigned         ADDR_W   = 14,
  parameter logic [ADDR_W-1:0]   RESET_PC = '0
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              launch,
  input  logic              req,
  input  logic              fetch_ok,
  input  logic              alt_sel,
  input  logic [ADDR_W-1:0] alt_addr,
  output logic [ADDR_W-1:0] pc,
  output logic [ADDR_W-1:0] fetch_addr
);
  logic [ADDR_W-1:0] pc_q, pc_d;
  logic [ADDR_W-1:0] fa_q, fa_d;
  logic              alt_q, alt_d;

  always_comb begin
    pc_d  = pc_q;
    fa_d  = fa_q;
    alt_d = alt_q;
    if (launch) begin
      fa_d  = alt_sel ? alt_addr : pc_q;
      alt_d = alt_sel;
    end
    if (fetch_ok && !alt_q) pc_d = pc_q + ADDR_W'(1);
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q  <= RESET_PC;
      fa_q  <= '0;
      alt_q <= 1'b0;
    end else begin
      pc_q  <= pc_d;
      fa_q  <= fa_d;
      alt_q <= alt_d;
    end
  end

  assign pc         = pc_q;
  assign fetch_addr = fa_q;

  // R2: sequential fetch advances the counter by one
  p_pc_step_r2: assert property (@(posedge clk) disable iff (!rst_ni)
    (fetch_ok && !alt_q) |=> (pc == $past(pc) + ADDR_W'(1)));
  // R3: alternate fetch leaves the counter alone
  p_pc_hold_r3: assert property (@(posedge clk) disable iff (!rst_ni)
    (fetch_ok && alt_q) |=> $stable(pc));
  // R4: address steady while waiting on memory
  p_addr_stable_r4: assert property (@(posedge clk) disable iff (!rst_ni)
    (req && !fetch_ok) |=> $stable(fetch_addr));
endmodule

// File: rtl/ifam_idx_file.sv
module ifam_idx_file #(
  parameter int unsigned ADDR_W = 14,
  parameter int unsigned TAG_W  = 3
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              we,
  input  logic [TAG_W-1:0]  wsel,
  input  logic [ADDR_W-1:0] wdata,
  input  logic [TAG_W-1:0]  rsel,
  output logic [ADDR_W-1:0] rdata
);
  localparam int unsigned NCELL = (1 << TAG_W) - 1;

  logic [(NCELL+1)*ADDR_W-1:0] flat;

  assign flat[ADDR_W-1:0] = '0;

  for (genvar g = 1; g <= NCELL; g++) begin : g_cell
    logic [ADDR_W-1:0] val_q;
    logic              hit;
    assign hit = we && (wsel == TAG_W'(g));
    always_ff @(posedge clk or negedge rst_ni) begin
      if (!rst_ni)  val_q <= '0;
      else if (hit) val_q <= wdata;
    end
    assign flat[g*ADDR_W +: ADDR_W] = val_q;
  end

  assign rdata = flat[int'(rsel)*ADDR_W +: ADDR_W];

  // R10: a write lands in the selected cell at the next edge
  p_write_lands_r10: assert property (@(posedge clk) disable iff (!rst_ni)
    (we && (wsel != '0) && (rsel == wsel)) |=> (rdata == $past(wdata)));
endmodule

// File: rtl/ifam_decode.sv
module ifam_decode #(
  parameter int unsigned WORD_W = 24,
  parameter int unsigned ADDR_W = 14,
  parameter int unsigned TAG_W  = 3
) (
  input  logic                     clk,
  input  logic                     rst_ni,
  input  logic                     fetch_ok,
  input  logic [WORD_W-1:0]        mem_rdata,
  input  logic                     ld_ir,
  input  logic                     idx_step,
  input  logic [ADDR_W-1:0]        base_addr,
  input  logic [ADDR_W-1:0]        idx_val,
  output logic [TAG_W-1:0]         tag,
  output logic                     tag_nz,
  output logic [WORD_W-ADDR_W-1:0] ir_opcode,
  output logic [ADDR_W-1:0]        ir_operand
);
  localparam int unsigned OPC_W   = WORD_W - ADDR_W;
  localparam int unsigned REL_BIT = ADDR_W;
  localparam int unsigned TAG_LO  = ADDR_W + 1;

  logic [WORD_W-1:0] buf_q, buf_d;
  logic [OPC_W-1:0]  opc_q, opc_d;
  logic [ADDR_W-1:0] opr_q, opr_d;
  logic [ADDR_W-1:0] rel_off;

  assign tag     = buf_q[TAG_LO +: TAG_W];
  assign tag_nz  = |tag;
  assign rel_off = buf_q[REL_BIT] ? base_addr : '0;

  always_comb begin
    buf_d = buf_q;
    opc_d = opc_q;
    opr_d = opr_q;
    if (fetch_ok) buf_d = mem_rdata;
    if (ld_ir) begin
      opc_d = buf_q[WORD_W-1:ADDR_W];
      opr_d = buf_q[ADDR_W-1:0] + rel_off;
    end else if (idx_step) begin
      opr_d = opr_q + idx_val;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      buf_q <= '0;
      opc_q <= '0;
      opr_q <= '0;
    end else begin
      buf_q <= buf_d;
      opc_q <= opc_d;
      opr_q <= opr_d;
    end
  end

  assign ir_opcode  = opc_q;
  assign ir_operand = opr_q;

  // R8: the index cycle touches only the operand
  p_idx_keeps_opcode_r8: assert property (@(posedge clk) disable iff (!rst_ni)
    idx_step |=> $stable(ir_opcode));
  // R11: instruction register holds outside decode and index cycles
  p_ir_hold_r11: assert property (@(posedge clk) disable iff (!rst_ni)
    (!ld_ir && !idx_step) |=> ($stable(ir_operand) && $stable(ir_opcode)));
endmodule

// File: rtl/ifetch_addr_mod.sv
module ifetch_addr_mod #(
  parameter int unsigned       WORD_W   = 24,
  parameter int unsigned       ADDR_W   = 14,
  parameter int unsigned       TAG_W    = 3,
  parameter logic [ADDR_W-1:0] RESET_PC = '0
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     fetch_start,
  input  logic                     alt_sel,
  input  logic [ADDR_W-1:0]        alt_addr,
  output logic                     mem_req,
  output logic [ADDR_W-1:0]        mem_addr,
  input  logic                     mem_rdy,
  input  logic [WORD_W-1:0]        mem_rdata,
  input  logic                     idx_we,
  input  logic [TAG_W-1:0]         idx_wsel,
  input  logic [ADDR_W-1:0]        idx_wdata,
  output logic [ADDR_W-1:0]        pc,
  output logic [WORD_W-ADDR_W-1:0] ir_opcode,
  output logic [ADDR_W-1:0]        ir_operand,
  output logic                     busy,
  output logic                     fetch_done
);
  logic              rst_ni;
  logic              launch, req, ld_ir, idx_step, fetch_ok;
  logic              tag_nz;
  logic [TAG_W-1:0]  tag;
  logic [ADDR_W-1:0] fetch_addr, idx_val;

  assign fetch_ok = req && mem_rdy;

  ifam_rst_sync u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_ni (rst_ni)
  );

  ifam_seq u_seq (
    .clk      (clk),
    .rst_ni   (rst_ni),
    .start    (fetch_start),
    .mem_rdy  (mem_rdy),
    .tag_nz   (tag_nz),
    .launch   (launch),
    .req      (req),
    .ld_ir    (ld_ir),
    .idx_step (idx_step),
    .busy     (busy),
    .done     (fetch_done)
  );

  ifam_addr #(.ADDR_W(ADDR_W), .RESET_PC(RESET_PC)) u_addr (
    .clk        (clk),
    .rst_ni     (rst_ni),
    .launch     (launch),
    .req        (req),
    .fetch_ok   (fetch_ok),
    .alt_sel    (alt_sel),
    .alt_addr   (alt_addr),
    .pc         (pc),
    .fetch_addr (fetch_addr)
  );

  ifam_idx_file #(.ADDR_W(ADDR_W), .TAG_W(TAG_W)) u_idx (
    .clk    (clk),
    .rst_ni (rst_ni),
    .we     (idx_we),
    .wsel   (idx_wsel),
    .wdata  (idx_wdata),
    .rsel   (tag),
    .rdata  (idx_val)
  );

  ifam_decode #(.WORD_W(WORD_W), .ADDR_W(ADDR_W), .TAG_W(TAG_W)) u_dec (
    .clk        (clk),
    .rst_ni     (rst_ni),
    .fetch_ok   (fetch_ok),
    .mem_rdata  (mem_rdata),
    .ld_ir      (ld_ir),
    .idx_step   (idx_step),
    .base_addr  (fetch_addr),
    .idx_val    (idx_val),
    .tag        (tag),
    .tag_nz     (tag_nz),
    .ir_opcode  (ir_opcode),
    .ir_operand (ir_operand)
  );

  assign mem_req  = req;
  assign mem_addr = fetch_addr;

  // R1: nothing requested while idle
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_ni)
    !busy |-> (!mem_req && !fetch_done) || fetch_done && !mem_req);
endmodule

// File: tb/tb_ifetch_addr_mod.sv
module tb_ifetch_addr_mod;
  localparam int unsigned      WORD_W = 24;
  localparam int unsigned      ADDR_W = 14;
  localparam int unsigned      TAG_W  = 3;
  localparam logic [13:0]      RST_PC = 14'h3FFE;

  typedef struct packed {
    logic        alt;
    logic [13:0] aaddr;
    logic [23:0] word;
    logic [1:0]  wt;
  } vec_t;

  // word layout: [23:18] opcode top, [17:15] tag, [14] relative, [13:0] operand
  localparam vec_t VEC [8] = '{
    '{1'b0, 14'h0000, {6'h11, 3'd0, 1'b0, 14'h0123}, 2'd0},
    '{1'b0, 14'h0000, {6'h3F, 3'd0, 1'b1, 14'h0005}, 2'd1},
    '{1'b1, 14'h1200, {6'h05, 3'd2, 1'b0, 14'h0010}, 2'd2},
    '{1'b0, 14'h0000, {6'h20, 3'd7, 1'b0, 14'h0002}, 2'd0},
    '{1'b0, 14'h0000, {6'h01, 3'd3, 1'b1, 14'h3FF0}, 2'd1},
    '{1'b1, 14'h3FFF, {6'h2A, 3'd0, 1'b1, 14'h0002}, 2'd3},
    '{1'b0, 14'h0000, {6'h00, 3'd1, 1'b0, 14'h0000}, 2'd0},
    '{1'b0, 14'h0000, {6'h3F, 3'd5, 1'b1, 14'h3FFF}, 2'd1}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fetch_start = 1'b0;
  logic        alt_sel = 1'b0;
  logic [13:0] alt_addr = '0;
  logic        mem_req;
  logic [13:0] mem_addr;
  logic        mem_rdy = 1'b0;
  logic [23:0] mem_rdata = '0;
  logic        idx_we = 1'b0;
  logic [2:0]  idx_wsel = '0;
  logic [13:0] idx_wdata = '0;
  logic [13:0] pc;
  logic [9:0]  ir_opcode;
  logic [13:0] ir_operand;
  logic        busy;
  logic        fetch_done;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  logic [13:0] pc_m;
  logic [13:0] cell_m [8];

  always #5 clk = ~clk;

  ifetch_addr_mod #(.WORD_W(WORD_W), .ADDR_W(ADDR_W), .TAG_W(TAG_W), .RESET_PC(RST_PC)) dut (
    .clk(clk), .rst_n(rst_n), .fetch_start(fetch_start), .alt_sel(alt_sel),
    .alt_addr(alt_addr), .mem_req(mem_req), .mem_addr(mem_addr), .mem_rdy(mem_rdy),
    .mem_rdata(mem_rdata), .idx_we(idx_we), .idx_wsel(idx_wsel), .idx_wdata(idx_wdata),
    .pc(pc), .ir_opcode(ir_opcode), .ir_operand(ir_operand), .busy(busy),
    .fetch_done(fetch_done)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr_cell(input logic [2:0] sel, input logic [13:0] val);
    @(negedge clk);
    idx_we = 1'b1; idx_wsel = sel; idx_wdata = val;
    @(negedge clk);
    idx_we = 1'b0;
    if (sel != 3'd0) cell_m[sel] = val;
  endtask

  task automatic fetch_one(input logic alt, input logic [13:0] aaddr,
                           input logic [23:0] word, input int wt);
    logic [13:0] fa, opr, opr_hold;
    logic [2:0]  tg;
    int          n, lat;
    string       rq;
    fa  = alt ? aaddr : pc_m;
    tg  = word[17:15];
    opr = word[13:0];
    if (word[14]) opr = opr + fa;
    if (tg != 3'd0) opr = opr + cell_m[tg];
    lat = (tg != 3'd0) ? 3 : 2;
    rq  = (tg != 3'd0) ? "R8" : (word[14] ? "R7" : "R6");
    if (!alt) pc_m = pc_m + 14'd1;

    @(negedge clk);
    fetch_start = 1'b1; alt_sel = alt; alt_addr = aaddr;
    @(negedge clk);
    fetch_start = 1'b0; alt_sel = 1'b0; alt_addr = '0;
    chk("R4 request", 32'(mem_req), 32'd1);
    chk(alt ? "R3 address" : "R2 address", 32'(mem_addr), 32'(fa));
    for (int i = 0; i < wt; i++) begin
      if (i == 0) fetch_start = 1'b1;
      @(negedge clk);
      fetch_start = 1'b0;
      chk("R4 held address", 32'(mem_addr), 32'(fa));
    end
    mem_rdy = 1'b1; mem_rdata = word;
    n = 0;
    do begin
      @(negedge clk);
      mem_rdy = 1'b0; mem_rdata = '0;
      n++;
    end while (!fetch_done && n < 8);
    chk((tg != 3'd0) ? "R8 latency" : "R9 latency", 32'(n), 32'(lat));
    chk("R5 opcode", 32'(ir_opcode), 32'(word[23:14]));
    chk(rq, 32'(ir_operand), 32'(opr));
    chk(alt ? "R3 pc" : "R2 pc", 32'(pc), 32'(pc_m));
    chk("R4 idle", 32'({busy, mem_req}), 32'd0);
    opr_hold = ir_operand;
    @(negedge clk);
    chk("R11 strobe", 32'(fetch_done), 32'd0);
    chk("R11 hold", 32'(ir_operand), 32'(opr_hold));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL R4 watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    pc_m = RST_PC;
    for (int k = 0; k < 8; k++) cell_m[k] = '0;
    repeat (2) @(negedge clk);
    // R1: reset state
    chk("R1 pc", 32'(pc), 32'(RST_PC));
    chk("R1 outputs", 32'({mem_req, busy, fetch_done}), 32'd0);
    chk("R1 ir", 32'({ir_opcode, ir_operand}), 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    wr_cell(3'd2, 14'h0100);
    wr_cell(3'd3, 14'h0020);
    wr_cell(3'd5, 14'h2000);
    wr_cell(3'd7, 14'h3FFF);

    for (int v = 0; v < 8; v++)
      fetch_one(VEC[v].alt, VEC[v].aaddr, VEC[v].word, int'(VEC[v].wt));

    // R10: rewrite a cell, newest value wins
    wr_cell(3'd4, 14'h0111);
    wr_cell(3'd4, 14'h0222);
    fetch_one(1'b0, 14'h0000, {6'h07, 3'd4, 1'b0, 14'h0001}, 0);
    chk("R10 rewritten cell", 32'(ir_operand), 32'h0223);

    // R1: asynchronous reset in the middle of a fetch
    @(negedge clk);
    fetch_start = 1'b1;
    @(negedge clk);
    fetch_start = 1'b0;
    chk("R1 pre-reset request", 32'(mem_req), 32'd1);
    rst_n = 1'b0;
    #1;
    chk("R1 async reset", 32'({mem_req, busy}), 32'd0);
    chk("R1 async pc", 32'(pc), 32'(RST_PC));
    pc_m = RST_PC;
    for (int k = 0; k < 8; k++) cell_m[k] = '0;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // cells cleared: indexed fetch adds zero
    fetch_one(1'b0, 14'h0000, {6'h12, 3'd7, 1'b0, 14'h0042}, 1);
    chk("R1 cleared cell", 32'(ir_operand), 32'h0042);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule